// File: doc/BRIEF.md
# Compare and Logic Flag ALU

This block is the execution slice of a 32-bit processor pipeline that handles magnitude comparison, bitwise logic and bit testing. The decode stage hands it a ready-selected destination operand, a register source operand, two 16-bit immediate fields, an operand-source select and a register-class bit. One clock after a valid strobe it presents the registered write-back value with a one-cycle write enable. In the same clock it updates a 16-bit status word that holds the zero, negative, carry and overflow flags.

A compare subtracts the source from the destination and sets all four flags, but writes nothing back. AND, OR, XOR and NOT write their result and set only the zero and negative flags. Bit test sets flags from the masked destination and leaves the registers alone. Two further operations merge a 16-bit immediate straight into the status word with AND or OR.

How an immediate is widened depends on the operation and on the register class. Compare against an address register treats a 16-bit immediate as unsigned. Compare against a data register treats it as signed.

Top module: `flag_alu`

## Requirements
- R1: A compare (op code 0) forms destination minus operand modulo 2^32. Status bit 0 (Z) is set when the difference is zero, and status bit 1 (N) equals bit 31 of the difference.
- R2: A compare sets status bit 2 (C) exactly when the operand, read as unsigned, is greater than the destination.
- R3: A compare sets status bit 3 (V) exactly when the signed difference does not fit in 32 bits, i.e. the operand signs differ and the difference sign differs from the destination sign.
- R4: A compare never raises wr_en_o and leaves result_o unchanged.
- R5: Operand select 0 uses src_i. Select 1 zero-extends imm_hi_i[7:0]. Select 2 takes imm_hi_i as the low half: it is sign-extended only for a compare whose reg_class_i is 0 (data), and zero-extended for class 1 (address) and for every other operation.
- R6: Operand select 3 forms the 32-bit operand as {imm_hi_i, imm_lo_i}.
- R7: AND (1), OR (2), XOR (3) and NOT (4, which inverts the destination) put their result on result_o with wr_en_o high for one cycle. Z and N come from that result, and C and V are cleared.
- R8: Bit test (5) sets Z and N from destination AND operand and clears C and V. It does not raise wr_en_o and leaves result_o unchanged.
- R9: Status-AND (6) and status-OR (7) combine imm_hi_i into the whole 16-bit status word. No flag is recomputed and nothing is written back.
- R10: Flag-updating operations change only status bits 3 to 0; bits 15 to 4 keep their value.
- R11: Synchronous reset clears status_o, result_o and wr_en_o. A cycle without valid_i changes no state and leaves wr_en_o low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 3 | Operation code |
| src_sel_i | input | 2 | Operand source: register, 8-, 16- or 32-bit immediate |
| reg_class_i | input | 1 | Destination class: 0 data, 1 address |
| dst_i | input | 32 | Destination register value |
| src_i | input | 32 | Source register value |
| imm_hi_i | input | 16 | Immediate field of the instruction word |
| imm_lo_i | input | 16 | Extension word (low half of 32-bit immediate) |
| result_o | output | 32 | Registered write-back value |
| wr_en_o | output | 1 | Write-back enable, one cycle per logic result |
| status_o | output | 16 | Status word |

## Verification
The bench builds the block with its default widths: a 32-bit datapath and 16-bit immediate halves and status word. This makes the sign-bit overflow boundaries (0x80000000 against 1, 0x7FFFFFFF against -1) and the bit-15 sign extension of a 16-bit immediate directly reachable with directed operands. The full 16-bit status word is exposed, so the bench can check that upper status bits set through status-OR survive later flag updates. Random traffic over all eight operations and four operand selects then mixes the cases.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

  typedef enum logic [2:0] {
    OP_CMP   = 3'd0,
    OP_AND   = 3'd1,
    OP_OR    = 3'd2,
    OP_XOR   = 3'd3,
    OP_NOT   = 3'd4,
    OP_BTST  = 3'd5,
    OP_STAND = 3'd6,
    OP_STOR  = 3'd7
  } alu_op_e;

  typedef enum logic [1:0] {
    SEL_REG   = 2'd0,
    SEL_IMM8  = 2'd1,
    SEL_IMM16 = 2'd2,
    SEL_IMM32 = 2'd3
  } opnd_sel_e;

  localparam int FLAG_Z = 0;
  localparam int FLAG_N = 1;
  localparam int FLAG_C = 2;
  localparam int FLAG_V = 3;
  localparam int FLAG_CNT = 4;

endpackage

// File: rtl/flag_alu_operand.sv
module flag_alu_operand
  import flag_alu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int HALF_W  = 16,
  parameter int SHORT_W = 8
) (
  input  logic [1:0]        src_sel,
  input  logic              signed_half,
  input  logic [DATA_W-1:0] src_reg,
  input  logic [HALF_W-1:0] imm_hi,
  input  logic [HALF_W-1:0] imm_lo,
  output logic [DATA_W-1:0] operand
);

  localparam int HALF_PAD  = DATA_W - HALF_W;
  localparam int SHORT_PAD = DATA_W - SHORT_W;

  logic [DATA_W-1:0] short_ext;
  logic [DATA_W-1:0] half_ext;
  logic [DATA_W-1:0] full_imm;

  assign short_ext = {{SHORT_PAD{1'b0}}, imm_hi[SHORT_W-1:0]};

  generate
    if (HALF_PAD > 0) begin : g_half_pad
      logic pad_bit;
      assign pad_bit  = signed_half & imm_hi[HALF_W-1];
      assign half_ext = {{HALF_PAD{pad_bit}}, imm_hi};
    end else begin : g_half_full
      assign half_ext = imm_hi[DATA_W-1:0];
    end
  endgenerate

  assign full_imm = DATA_W'({imm_hi, imm_lo});

  always_comb begin
    unique case (opnd_sel_e'(src_sel))
      SEL_REG:   operand = src_reg;
      SEL_IMM8:  operand = short_ext;
      SEL_IMM16: operand = half_ext;
      default:   operand = full_imm;
    endcase
  end

endmodule

// File: rtl/flag_alu_core.sv
module flag_alu_core
  import flag_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [2:0]          op,
  input  logic [DATA_W-1:0]   dst,
  input  logic [DATA_W-1:0]   operand,
  output logic [DATA_W-1:0]   value,
  output logic [FLAG_CNT-1:0] flags,
  output logic                flag_upd,
  output logic                wr_back
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W:0] diff_ext;
  logic            borrow;
  logic            ovf;

  assign diff_ext = {1'b0, dst} - {1'b0, operand};
  assign borrow   = diff_ext[DATA_W];
  assign ovf      = (dst[MSB] != operand[MSB]) && (dst[MSB] != diff_ext[MSB]);

  always_comb begin
    value    = '0;
    flag_upd = 1'b1;
    wr_back  = 1'b0;
    unique case (alu_op_e'(op))
      OP_CMP:  value = diff_ext[DATA_W-1:0];
      OP_AND:  begin value = dst & operand; wr_back = 1'b1; end
      OP_OR:   begin value = dst | operand; wr_back = 1'b1; end
      OP_XOR:  begin value = dst ^ operand; wr_back = 1'b1; end
      OP_NOT:  begin value = ~dst;          wr_back = 1'b1; end
      OP_BTST: value = dst & operand;
      default: flag_upd = 1'b0;
    endcase
  end

  always_comb begin
    flags         = '0;
    flags[FLAG_Z] = (value == '0);
    flags[FLAG_N] = value[MSB];
    if (alu_op_e'(op) == OP_CMP) begin
      flags[FLAG_C] = borrow;
      flags[FLAG_V] = ovf;
    end
  end

endmodule

// File: rtl/flag_alu_status.sv
module flag_alu_status
  import flag_alu_pkg::*;
#(
  parameter int STAT_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                valid,
  input  logic [2:0]          op,
  input  logic                flag_upd,
  input  logic [FLAG_CNT-1:0] flags,
  input  logic [STAT_W-1:0]   imm,
  output logic [STAT_W-1:0]   status
);

  localparam logic [STAT_W-1:0] FLAG_MASK = STAT_W'((1 << FLAG_CNT) - 1);

  logic [STAT_W-1:0] next_status;

  always_comb begin
    next_status = status;
    if (flag_upd) begin
      next_status = (status & ~FLAG_MASK) | STAT_W'(flags);
    end else if (alu_op_e'(op) == OP_STAND) begin
      next_status = status & imm;
    end else if (alu_op_e'(op) == OP_STOR) begin
      next_status = status | imm;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
    end else if (valid) begin
      status <= next_status;
    end
  end

endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import flag_alu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int HALF_W  = 16,
  parameter int SHORT_W = 8,
  parameter int STAT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid_i,
  input  logic [2:0]        op_i,
  input  logic [1:0]        src_sel_i,
  input  logic              reg_class_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [HALF_W-1:0] imm_hi_i,
  input  logic [HALF_W-1:0] imm_lo_i,
  output logic [DATA_W-1:0] result_o,
  output logic              wr_en_o,
  output logic [STAT_W-1:0] status_o
);

  logic                signed_half;
  logic [DATA_W-1:0]   operand;
  logic [DATA_W-1:0]   value;
  logic [FLAG_CNT-1:0] flags;
  logic                flag_upd;
  logic                wr_back;

  assign signed_half = (alu_op_e'(op_i) == OP_CMP) && !reg_class_i;

  flag_alu_operand #(
    .DATA_W (DATA_W),
    .HALF_W (HALF_W),
    .SHORT_W(SHORT_W)
  ) u_operand (
    .src_sel    (src_sel_i),
    .signed_half(signed_half),
    .src_reg    (src_i),
    .imm_hi     (imm_hi_i),
    .imm_lo     (imm_lo_i),
    .operand    (operand)
  );

  flag_alu_core #(
    .DATA_W(DATA_W)
  ) u_core (
    .op      (op_i),
    .dst     (dst_i),
    .operand (operand),
    .value   (value),
    .flags   (flags),
    .flag_upd(flag_upd),
    .wr_back (wr_back)
  );

  flag_alu_status #(
    .STAT_W(STAT_W)
  ) u_status (
    .clk     (clk),
    .rst     (rst),
    .valid   (valid_i),
    .op      (op_i),
    .flag_upd(flag_upd),
    .flags   (flags),
    .imm     (STAT_W'(imm_hi_i)),
    .status  (status_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
      wr_en_o  <= 1'b0;
    end else begin
      wr_en_o <= valid_i && wr_back;
      if (valid_i && wr_back) begin
        result_o <= value;
      end
    end
  end

endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk #(
  parameter int DATA_W = 32,
  parameter int HALF_W = 16,
  parameter int STAT_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              valid_i,
  input logic [2:0]        op_i,
  input logic [HALF_W-1:0] imm_hi_i,
  input logic [DATA_W-1:0] result_o,
  input logic              wr_en_o,
  input logic [STAT_W-1:0] status_o
);

  logic is_logic;
  assign is_logic = (op_i >= 3'd1) && (op_i <= 3'd4);

  p_rst_clear_r11: assert property (@(posedge clk)
    rst |=> (status_o == '0) && !wr_en_o && (result_o == '0));

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> $stable(status_o) && $stable(result_o) && !wr_en_o);

  p_cmp_nowrite_r4: assert property (@(posedge clk) disable iff (rst)
    (valid_i && op_i == 3'd0) |=> !wr_en_o && $stable(result_o));

  p_logic_flags_r7: assert property (@(posedge clk) disable iff (rst)
    (valid_i && is_logic) |=> wr_en_o && !status_o[2] && !status_o[3]
      && (status_o[0] == (result_o == '0)) && (status_o[1] == result_o[DATA_W-1]));

  p_btst_nowrite_r8: assert property (@(posedge clk) disable iff (rst)
    (valid_i && op_i == 3'd5) |=> !wr_en_o && $stable(result_o)
      && !status_o[2] && !status_o[3]);

  p_upper_keep_r10: assert property (@(posedge clk) disable iff (rst)
    (valid_i && op_i <= 3'd5) |=> (status_o[STAT_W-1:4] == $past(status_o[STAT_W-1:4])));

  p_stat_and_r9: assert property (@(posedge clk) disable iff (rst)
    (valid_i && op_i == 3'd6) |=> (status_o == ($past(status_o) & STAT_W'($past(imm_hi_i)))) && !wr_en_o);

  p_stat_or_r9: assert property (@(posedge clk) disable iff (rst)
    (valid_i && op_i == 3'd7) |=> (status_o == ($past(status_o) | STAT_W'($past(imm_hi_i)))) && !wr_en_o);

endmodule

bind flag_alu flag_alu_chk #(
  .DATA_W(DATA_W),
  .HALF_W(HALF_W),
  .STAT_W(STAT_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .valid_i (valid_i),
  .op_i    (op_i),
  .imm_hi_i(imm_hi_i),
  .result_o(result_o),
  .wr_en_o (wr_en_o),
  .status_o(status_o)
);

// File: tb/tb_flag_alu.sv
module tb_flag_alu;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [1:0]  src_sel_i = '0;
  logic        reg_class_i = 1'b0;
  logic [31:0] dst_i = '0;
  logic [31:0] src_i = '0;
  logic [15:0] imm_hi_i = '0;
  logic [15:0] imm_lo_i = '0;
  logic [31:0] result_o;
  logic        wr_en_o;
  logic [15:0] status_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  logic [15:0] m_status = '0;
  logic [31:0] m_result = '0;
  logic        m_wr     = 1'b0;

  always #2 clk = ~clk;

  flag_alu dut (
    .clk(clk), .rst(rst), .valid_i(valid_i), .op_i(op_i),
    .src_sel_i(src_sel_i), .reg_class_i(reg_class_i),
    .dst_i(dst_i), .src_i(src_i), .imm_hi_i(imm_hi_i), .imm_lo_i(imm_lo_i),
    .result_o(result_o), .wr_en_o(wr_en_o), .status_o(status_o)
  );

  function automatic string tag_of(input int op, input int sel);
    if (op == 0) return (sel == 0) ? "R1 R2 R3 R4" : ((sel == 3) ? "R6" : "R5");
    if (op <= 4) return "R7";
    if (op == 5) return "R8";
    return "R9";
  endfunction

  task automatic compare(input string tag);
    n_checks++;
    if (status_o !== m_status || result_o !== m_result || wr_en_o !== m_wr) begin
      n_fails++;
      $display("FAIL %s: status=%h result=%h wr=%b expected status=%h result=%h wr=%b",
               tag, status_o, result_o, wr_en_o, m_status, m_result, m_wr);
    end
  endtask

  // Behavioural reference: builds the expected state after the coming edge.
  task automatic model(input int op, input int sel, input bit cls,
                       input logic [31:0] d, input logic [31:0] s,
                       input logic [15:0] hi, input logic [15:0] lo);
    logic [31:0] b;
    logic [31:0] r;
    longint sd;
    bit z, n, c, v;
    case (sel)
      0: b = s;
      1: b = {24'd0, hi[7:0]};
      2: b = (op == 0 && !cls) ? 32'($signed(hi)) : {16'd0, hi};
      default: b = {hi, lo};
    endcase
    c = 0; v = 0; r = 0;
    case (op)
      0: begin
        r  = d - b;
        c  = (b > d);
        sd = longint'($signed(d)) - longint'($signed(b));
        v  = (sd > 64'sd2147483647) || (sd < -64'sd2147483648);
      end
      1: r = d & b;
      2: r = d | b;
      3: r = d ^ b;
      4: r = ~d;
      5: r = d & b;
      default: r = 0;
    endcase
    z = (r == 0);
    n = r[31];
    m_wr = (op >= 1 && op <= 4);
    if (m_wr) m_result = r;
    if (op <= 5) m_status = {m_status[15:4], v, c, n, z};
    else if (op == 6) m_status = m_status & hi;
    else m_status = m_status | hi;
  endtask

  task automatic issue(input int op, input int sel, input bit cls,
                       input logic [31:0] d, input logic [31:0] s,
                       input logic [15:0] hi, input logic [15:0] lo, input string tag);
    valid_i = 1'b1; op_i = 3'(op); src_sel_i = 2'(sel); reg_class_i = cls;
    dst_i = d; src_i = s; imm_hi_i = hi; imm_lo_i = lo;
    model(op, sel, cls, d, s, hi, lo);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(input string tag);
    valid_i = 1'b0;
    op_i = 3'(($urandom % 8)); dst_i = $urandom; imm_hi_i = 16'(($urandom));
    m_wr = 1'b0;
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    compare("R11 reset");
    // R1 equal compare -> Z
    issue(0, 0, 0, 32'h1234_5678, 32'h1234_5678, 0, 0, "R1 zero");
    // R2 borrow and negative
    issue(0, 0, 0, 32'h0, 32'h1, 0, 0, "R2 borrow");
    // R3 overflow both directions
    issue(0, 0, 1, 32'h8000_0000, 32'h1, 0, 0, "R3 overflow neg");
    issue(0, 0, 0, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 0, 0, "R3 overflow pos");
    // R4 compare after a write keeps result
    issue(1, 0, 0, 32'hF0F0_F0F0, 32'hFF00_FF00, 0, 0, "R7 and");
    issue(0, 0, 0, 32'h5, 32'h3, 0, 0, "R4 cmp no write");
    // R5 immediates
    issue(0, 1, 0, 32'h0000_00FF, 32'h0, 16'hAAFF, 0, "R5 imm8 zero-ext");
    issue(0, 2, 0, 32'hFFFF_8000, 32'h0, 16'h8000, 0, "R5 imm16 data signed");
    issue(0, 2, 1, 32'hFFFF_8000, 32'h0, 16'h8000, 0, "R5 imm16 addr unsigned");
    issue(2, 2, 0, 32'h0, 32'h0, 16'h8001, 0, "R5 logic imm16 zero-ext");
    // R6 32-bit immediate
    issue(0, 3, 0, 32'hDEAD_BEEF, 32'h0, 16'hDEAD, 16'hBEEF, "R6 imm32 cmp");
    issue(3, 3, 0, 32'hFFFF_FFFF, 32'h0, 16'h8000, 16'h0001, "R6 imm32 xor");
    // R7 not, zero result
    issue(4, 0, 0, 32'hFFFF_FFFF, 32'h0, 0, 0, "R7 not zero");
    issue(4, 0, 0, 32'h0, 32'h0, 0, 0, "R7 not neg");
    // R9 status ops, then R10 upper bits survive
    issue(7, 0, 0, 0, 0, 16'hA5F0, 0, "R9 status or");
    issue(6, 0, 0, 0, 0, 16'hFF3F, 0, "R9 status and");
    issue(0, 0, 0, 32'h0, 32'h1, 0, 0, "R10 upper kept");
    // R8 bit test
    issue(5, 3, 0, 32'h8000_0001, 32'h0, 16'h8000, 16'h0000, "R8 btst neg");
    issue(5, 1, 0, 32'hFFFF_FF00, 32'h0, 16'h00FF, 0, "R8 btst zero");
    idle("R11 idle");
    idle("R11 idle");
    for (int i = 0; i < 400; i++) begin
      int op, sel;
      op  = $urandom % 8;
      sel = $urandom % 4;
      if ($urandom % 6 == 0) idle("R11 idle");
      else issue(op, sel, 1'($urandom), $urandom, $urandom,
                 16'($urandom), 16'($urandom), tag_of(op, sel));
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

endmodule